// File: doc/BRIEF.md
# Block Burst Sequencer with Inhibit Fallback

This master-side sequencer moves an aligned block of four or eight 32-bit words over an external bus whose data port is 32, 16 or 8 bits wide. The port width comes from a memory-controller input and is sampled when a request is accepted. Every block starts as a burst: one transfer start and a single address, with the slave stepping through the beats on its own. A burst-in-progress flag tells the slave when the final beat has arrived.

Some slaves cannot burst. Such a slave answers the first beat with a burst-inhibit flag. The sequencer then drops the burst and fetches the rest of that 16-byte block with single-beat cycles, each with its own address. On a narrow port, a burst is stretched to 8 or 16 beats per 16 bytes. Read bytes or halfwords are packed into words, and write words are split across the upper lanes. While a transaction runs, the grant offered to other masters stays low, so the whole exchange is atomic.

Top module: `burst_seq`

## Requirements
- R1: A request is taken only when idle. The block base is the request address with its low 4 bits cleared (four words) or low 5 bits cleared (eight words). Every transfer start (`bus_ts`) lasts exactly one cycle and carries the byte address of its first beat. During a burst data phase the address does not change.
- R2: The port code is 0 = 32-bit, 1 = 16-bit, 2 = 8-bit, and 3 is treated as 32-bit. Each beat moves 4, 2 or 1 bytes. When no slave inhibits, a request is one burst of words×4/bytes-per-beat beats: 4/8 beats at 32-bit, 8/16 at 16-bit, 16/32 at 8-bit.
- R3: `bus_bdip` is high throughout a burst except in the cycles of its final expected beat, where it is low. It is always low when `bus_burst` is low.
- R4: If `bus_bi` arrives with the acknowledge of the first beat of a burst, the burst ends after that beat. The remaining beats of that 16-byte block follow as single cycles (`bus_burst` low), each at its own byte address. That is 3, 7 or 15 single cycles for a 32-, 16- or 8-bit port.
- R5: For an eight-word request whose first block fell back to single cycles, the second 16-byte block begins with a fresh burst attempt at base+16. That attempt is subject to the same inhibit rule.
- R6: Reads on a narrow port take data from `bus_rdata[31:16]` (16-bit) or `bus_rdata[31:24]` (8-bit). Beats are packed big-endian, with the lowest address in bits 31:24. One cycle after the acknowledge of a word's last beat, `word_valid` pulses with `word_idx` (the word offset from the base) and `word_data`.
- R7: On writes, `wr_idx` names the word being sent. `bus_wdata` carries that word's bytes for the current beat in the upper lanes, in big-endian order. `word_valid` stays low on writes.
- R8: `bus_gnt_o` is low in any cycle where `req` is high or a transaction is in progress, up to and including the final acknowledge. Otherwise it is high.
- R9: `done` pulses one cycle after the final acknowledge, with `busy` already low. After reset, `busy`, `bus_ts` and `done` are low and `bus_gnt_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start a block transaction (taken when idle) |
| req_addr | input | ADDR_W | Byte address inside the block |
| req_eight | input | 1 | 1 = eight words, 0 = four words |
| req_write | input | 1 | 1 = write, 0 = read |
| port_size | input | 2 | Slave port width code from the memory controller |
| wr_word | input | 32 | Write word selected by `wr_idx` |
| wr_idx | output | 3 | Index of the word currently being written |
| bus_addr | output | ADDR_W | Bus byte address |
| bus_ts | output | 1 | Transfer start |
| bus_burst | output | 1 | Current cycle is a burst |
| bus_bdip | output | 1 | More burst beats follow |
| bus_write | output | 1 | Direction of the transaction |
| bus_wdata | output | 32 | Write data lanes |
| bus_rdata | input | 32 | Read data lanes |
| bus_ta | input | 1 | Beat acknowledge from the slave |
| bus_bi | input | 1 | Burst inhibit from the slave |
| bus_gnt_o | output | 1 | Bus grant offered to other masters |
| busy | output | 1 | Transaction in progress |
| word_valid | output | 1 | A read word is complete |
| word_idx | output | 3 | Index of the completed word |
| word_data | output | 32 | Completed read word |
| done | output | 1 | Transaction finished |

## Verification
The bench sweeps every combination of port code (including the spare code 3), block length, direction, burst inhibit on or off, and zero or one wait state. The total acknowledge count separates the port widths. The number of transfer starts, and of those that are bursts, separates a burst that was accepted from one that fell back, and shows whether the second block of an eight-word request tried a new burst. Every transfer-start address and every packed word or written byte is compared with arithmetic over the bench's byte memory. The wait-state variants show that the sequencer relies on the acknowledge and not on a fixed cycle count.

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_eight,
  input  logic              req_write,
  input  logic [1:0]        port_size,
  input  logic [31:0]       wr_word,
  output logic [2:0]        wr_idx,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_ts,
  output logic              bus_burst,
  output logic              bus_bdip,
  output logic              bus_write,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_ta,
  input  logic              bus_bi,
  output logic              bus_gnt_o,
  output logic              busy,
  output logic              word_valid,
  output logic [2:0]        word_idx,
  output logic [31:0]       word_data,
  output logic              done
);

  localparam int OW = 5;
  localparam int CW = OW + 1;

  typedef enum logic [2:0] {S_IDLE, S_BTS, S_BDATA, S_STS, S_SDATA} st_t;

  st_t               st;
  logic [ADDR_W-1:0] base_q;
  logic              eight_q, wr_q;
  logic [1:0]        sh_q;
  logic [OW-1:0]     bcnt, bfirst;
  logic [31:0]       acc, acc_nx, lane_mask;

  wire [1:0]    sh_in    = (port_size == 2'd3) ? 2'd0 : port_size;
  wire [CW-1:0] total    = (eight_q ? CW'(8) : CW'(4)) << sh_q;
  wire [OW-1:0] last     = OW'(total - CW'(1));
  wire [OW-1:0] blk_mask = OW'((CW'(4) << sh_q) - CW'(1));
  wire          blk_end  = (bcnt & blk_mask) == blk_mask;
  wire          in_burst = (st == S_BTS) || (st == S_BDATA);
  wire          in_data  = (st == S_BDATA) || (st == S_SDATA);
  wire          ta_ok    = in_data && bus_ta;
  wire          is_last  = bcnt == last;
  wire [1:0]    step     = 2'd2 - sh_q;
  wire [OW-1:0] cur_byte = bcnt << step;
  wire [OW-1:0] adr_byte = (in_burst ? bfirst : bcnt) << step;
  wire          sub_last = &(cur_byte[1:0] | (2'b11 >> sh_q));
  wire [OW-1:0] widx     = bcnt >> sh_q;

  always_comb begin
    case (sh_q)
      2'd1:    begin acc_nx = {acc[15:0], bus_rdata[31:16]}; lane_mask = 32'hFFFF_0000; end
      2'd2:    begin acc_nx = {acc[23:0], bus_rdata[31:24]}; lane_mask = 32'hFF00_0000; end
      default: begin acc_nx = bus_rdata;                     lane_mask = 32'hFFFF_FFFF; end
    endcase
  end

  assign bus_addr  = base_q | {{(ADDR_W-OW){1'b0}}, adr_byte};
  assign bus_ts    = (st == S_BTS) || (st == S_STS);
  assign bus_burst = in_burst;
  assign bus_bdip  = in_burst && !is_last;
  assign bus_write = wr_q;
  assign bus_wdata = (wr_word << {cur_byte[1:0], 3'b000}) & lane_mask;
  assign wr_idx    = widx[2:0];
  assign busy      = st != S_IDLE;
  assign bus_gnt_o = (st == S_IDLE) && !req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      base_q     <= '0;
      eight_q    <= 1'b0;
      wr_q       <= 1'b0;
      sh_q       <= 2'd0;
      bcnt       <= '0;
      bfirst     <= '0;
      acc        <= '0;
      word_valid <= 1'b0;
      word_idx   <= '0;
      word_data  <= '0;
      done       <= 1'b0;
    end else begin
      word_valid <= ta_ok && sub_last && !wr_q;
      done       <= ta_ok && is_last;
      if (ta_ok) begin
        acc       <= acc_nx;
        word_idx  <= widx[2:0];
        word_data <= acc_nx;
      end
      case (st)
        S_IDLE: if (req) begin
          base_q  <= req_addr & ~{{(ADDR_W-OW){1'b0}}, req_eight, 4'hF};
          eight_q <= req_eight;
          wr_q    <= req_write;
          sh_q    <= sh_in;
          bcnt    <= '0;
          bfirst  <= '0;
          st      <= S_BTS;
        end
        S_BTS: st <= S_BDATA;
        S_BDATA: if (bus_ta) begin
          bcnt <= bcnt + OW'(1);
          if (is_last)                     st <= S_IDLE;
          else if (bus_bi && bcnt == bfirst) st <= S_STS;
        end
        S_STS: st <= S_SDATA;
        S_SDATA: if (bus_ta) begin
          bcnt <= bcnt + OW'(1);
          if (is_last)      st <= S_IDLE;
          else if (blk_end) begin
            bfirst <= bcnt + OW'(1);
            st     <= S_BTS;
          end else          st <= S_STS;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ts,
  input logic              bus_burst,
  input logic              bus_bdip,
  input logic              bus_ta,
  input logic              bus_bi,
  input logic              bus_gnt_o,
  input logic              busy,
  input logic              done
);

  logic first_beat;
  always_ff @(posedge clk) begin
    if (!rst_n)       first_beat <= 1'b0;
    else if (bus_ts)  first_beat <= bus_burst;
    else if (bus_ta)  first_beat <= 1'b0;
  end

  // R1
  ts_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ts |=> !bus_ts);

  // R1
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_burst && !bus_ts && $past(bus_burst)) |-> $stable(bus_addr));

  // R3
  bdip_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_burst |-> !bus_bdip);

  // R3
  bdip_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ta && bus_burst && !bus_ts && !bus_bdip) |=> done);

  // R4
  inhibit_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (first_beat && bus_ta && bus_bi && bus_bdip && !bus_ts) |=> (bus_ts && !bus_burst));

  // R8
  gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || req) |-> !bus_gnt_o);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind burst_seq burst_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .bus_addr(bus_addr), .bus_ts(bus_ts),
  .bus_burst(bus_burst), .bus_bdip(bus_bdip), .bus_ta(bus_ta), .bus_bi(bus_bi),
  .bus_gnt_o(bus_gnt_o), .busy(busy), .done(done)
);

// File: tb/burst_seq_tb.sv
module burst_seq_tb;
  localparam int CLK_NS = 10;
  localparam int WD_CYCLES = 150000;
  localparam logic [31:0] BASE = 32'h1000_0034;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic req = 0, req_eight = 0, req_write = 0;
  logic [31:0] req_addr = '0;
  logic [1:0] port_size = '0;
  logic [31:0] wr_word, bus_addr, bus_wdata, bus_rdata, word_data;
  logic [2:0] wr_idx, word_idx;
  logic bus_ts, bus_burst, bus_bdip, bus_write, bus_ta, bus_bi;
  logic bus_gnt_o, busy, word_valid, done;

  burst_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr), .req_eight(req_eight),
    .req_write(req_write), .port_size(port_size), .wr_word(wr_word), .wr_idx(wr_idx),
    .bus_addr(bus_addr), .bus_ts(bus_ts), .bus_burst(bus_burst), .bus_bdip(bus_bdip),
    .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ta(bus_ta),
    .bus_bi(bus_bi), .bus_gnt_o(bus_gnt_o), .busy(busy), .word_valid(word_valid),
    .word_idx(word_idx), .word_data(word_data), .done(done)
  );

  int checks = 0, errors = 0;
  int sh = 0, bpb = 4, waitn = 0;
  logic inh = 0;
  logic [31:0] align = '0;
  logic [7:0] mem [64];

  function automatic logic [31:0] wpat(input int k);
    return {8'(16*k+1), 8'(16*k+2), 8'(16*k+3), 8'(16*k+4)};
  endfunction
  assign wr_word = wpat(int'(wr_idx));

  function automatic logic [31:0] rlane(input logic [5:0] a);
    case (sh)
      1:       return {mem[a], mem[a+6'd1], 16'h0};
      2:       return {mem[a], 24'h0};
      default: return {mem[a], mem[a+6'd1], mem[a+6'd2], mem[a+6'd3]};
    endcase
  endfunction

  function automatic logic [31:0] mword(input logic [31:0] a);
    logic [5:0] b = a[5:0];
    return {mem[b], mem[b+6'd1], mem[b+6'd2], mem[b+6'd3]};
  endfunction

  // behavioural slave: stops a burst when bdip is low or after asserting inhibit
  logic s_act, s_bur, s_first;
  logic [5:0] s_adr;
  int s_wc;
  always @(posedge clk) begin
    if (!rst_n) begin
      s_act <= 0; s_bur <= 0; s_first <= 0; s_adr <= '0; s_wc <= 0;
      bus_ta <= 0; bus_bi <= 0; bus_rdata <= '0;
      for (int i = 0; i < 64; i++) mem[i] <= 8'(i*37 + 5);
    end else begin
      bus_ta <= 0; bus_bi <= 0;
      if (bus_ts) begin
        s_act <= 1; s_adr <= bus_addr[5:0]; s_bur <= bus_burst; s_first <= 1; s_wc <= 0;
        if (waitn == 0) begin
          bus_ta <= 1; bus_rdata <= rlane(bus_addr[5:0]); bus_bi <= inh && bus_burst;
        end
      end else if (s_act) begin
        if (bus_ta) begin
          if (bus_write)
            for (int j = 0; j < bpb; j++) mem[s_adr + 6'(j)] <= bus_wdata[31-8*j -: 8];
          s_first <= 0;
          if (s_bur && bus_bdip && !bus_bi) begin
            s_adr <= s_adr + 6'(bpb); s_wc <= 0;
            if (waitn == 0) begin
              bus_ta <= 1; bus_rdata <= rlane(s_adr + 6'(bpb));
            end
          end else s_act <= 0;
        end else if (s_wc + 1 >= waitn) begin
          bus_ta <= 1; bus_rdata <= rlane(s_adr); bus_bi <= inh && s_bur && s_first;
        end else s_wc <= s_wc + 1;
      end
    end
  end

  // monitor
  logic clr = 0;
  int n_ts, n_bts, n_ta, n_wv, n_done, bad_adr, bad_bdip, bad_gnt, bad_data;
  logic [31:0] bad_act, bad_exp;
  always @(negedge clk) begin
    if (clr) begin
      n_ts <= 0; n_bts <= 0; n_ta <= 0; n_wv <= 0; n_done <= 0;
      bad_adr <= 0; bad_bdip <= 0; bad_gnt <= 0; bad_data <= 0;
    end else if (rst_n) begin
      if (bus_ts) begin
        n_ts <= n_ts + 1;
        if (bus_burst) n_bts <= n_bts + 1;
        if (bus_addr != align + 32'(n_ta*bpb)) bad_adr <= bad_adr + 1;
        if (!bus_burst && bus_bdip) bad_bdip <= bad_bdip + 1;
      end
      if (bus_ta && !bus_ts && busy) n_ta <= n_ta + 1;
      if (busy && bus_gnt_o) bad_gnt <= bad_gnt + 1;
      if (word_valid) begin
        n_wv <= n_wv + 1;
        if (word_data != mword(align + 32'(4*int'(word_idx)))) begin
          bad_data <= bad_data + 1; bad_act <= word_data;
          bad_exp <= mword(align + 32'(4*int'(word_idx)));
        end
      end
      if (done) n_done <= n_done + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (port=%0d inh=%0d wait=%0d)", tag, act, exp, port_size, inh, waitn);
    end
  endtask

  task automatic run(input int p, input bit e, input bit w, input bit i, input int wt);
    int words, total, blocks, guard;
    @(negedge clk);
    sh = (p == 3) ? 0 : p; bpb = 4 >> sh; inh = i; waitn = wt;
    align = BASE & ~(e ? 32'h1F : 32'h0F);
    words = e ? 8 : 4; total = words * (4 / bpb); blocks = words / 4;
    clr = 1; @(negedge clk); @(negedge clk); clr = 0;
    req = 1; req_addr = BASE; req_eight = e; req_write = w; port_size = 2'(p);
    #1;
    chk(!bus_gnt_o, "R8 grant low with req", 32'(bus_gnt_o), 0);
    @(negedge clk); req = 0;
    guard = 0;
    while (n_done == 0 && guard < 600) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
    chk(n_done == 1, "R9 one done pulse", 32'(n_done), 1);
    chk(!busy && bus_gnt_o, "R9 idle after done", {busy, bus_gnt_o}, 2'b01);
    chk(n_ta == total, "R2 beat count", 32'(n_ta), 32'(total));
    chk(n_ts == (i ? total : 1), "R4 transfer starts", 32'(n_ts), 32'(i ? total : 1));
    if (e && i) chk(n_bts == blocks, "R5 burst attempts", 32'(n_bts), 32'(blocks));
    else        chk(n_bts == 1, "R2 single burst", 32'(n_bts), 1);
    chk(bad_adr == 0, "R1 R4 start address", 32'(bad_adr), 0);
    chk(bad_bdip == 0, "R3 bdip on single", 32'(bad_bdip), 0);
    chk(bad_gnt == 0, "R8 grant while busy", 32'(bad_gnt), 0);
    if (w) begin
      chk(n_wv == 0, "R7 no word_valid on write", 32'(n_wv), 0);
      for (int k = 0; k < words; k++)
        chk(mword(align + 32'(4*k)) == wpat(k), "R7 written word", mword(align + 32'(4*k)), wpat(k));
    end else begin
      chk(n_wv == words, "R6 word count", 32'(n_wv), 32'(words));
      chk(bad_data == 0, "R6 packed data", bad_act, bad_exp);
    end
  endtask

  initial begin
    #(WD_CYCLES * CLK_NS);
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !bus_ts && !done, "R9 reset outputs", {busy, bus_ts, done}, 0);
    chk(bus_gnt_o, "R9 reset grant", 32'(bus_gnt_o), 1);
    for (int p = 0; p < 4; p++)
      for (int e = 0; e < 2; e++)
        for (int w = 0; w < 2; w++)
          for (int i = 0; i < 2; i++)
            for (int wt = 0; wt < 2; wt++)
              run(p, e[0], w[0], i[0], wt);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule